// File: doc/BRIEF.md
# Rate-Timed Envelope Generator with Piecewise-Exponential Fall

This block produces the 8-bit amplitude envelope of one synthesizer voice. A gate input opens and closes the note. While the gate is high the level climbs linearly to full scale and then falls to a programmable hold level. When the gate drops, the level falls to silence. Every step waits for a rate counter. The counter is a 15-bit linear-feedback shift register that returns to all-ones each time it reaches the comparison value for the selected rate. No binary counter is involved.

During the two falling phases, rate matches are thinned further by a small divider. The divider ratio depends on how low the level already is, so the falling curve approximates an exponential in six linear pieces. The block takes its rates and hold level from two control bytes, each split into nibbles. An enable input lets the parent clock the block at a slower tick rate.

Top module: `env_adsr_gen`

## Requirements
- R1: After reset, `env_level` is 0 and `env_phase` is 0. Phase codes are 0 = release, 1 = rising, 2 = falling toward hold, 3 = holding.
- R2: On an enabled tick where `gate` is 1 and was 0 on the previous enabled tick, the phase becomes 1. In phase 1 the level rises by exactly one per rate step. The tick that brings it to 255 also moves the phase to 2.
- R3: The rate in use is `atk_dcy[7:4]` in phase 1, `atk_dcy[3:0]` in phases 2 and 3, and `sus_rel[3:0]` in phase 0. Once the counter is aligned, rate values 0 to 15 give steps every 8, 31, 62, 94, 148, 219, 266, 312, 391, 976, 1953, 3125, 3906, 11719, 19531 and 31250 enabled ticks.
- R4: The hold level is `sus_rel[7:4]` times 17. In phase 2 the level falls until it equals the hold level. The phase then becomes 3 and the level stays put while the gate stays high.
- R5: On an enabled tick where `gate` is 0 and was 1, the phase becomes 0. From then on the level only falls, paced by the release rate.
- R6: In phases 0 and 2, a level step needs N rate matches, where N depends on the level before the step. N is 1 above 0x5D, 2 for 0x37 to 0x5D, 4 for 0x1B to 0x36, 8 for 0x0F to 0x1A, 16 for 0x07 to 0x0E, and 30 for 0x06 and below. Phase 1 ignores this ratio.
- R7: Once the level reaches 0 in a falling phase, it stays at 0 until the next rising gate edge.
- R8: The counter restarts only on a match with the current rate. If the rate changes to a value the counter has already passed, the next step comes only after the register wraps through all 32767 states. At rate 0 that makes the gap 32775 ticks from the previous step.
- R9: While `clk_en` is 0, no state changes, including the remembered gate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Tick enable; state advances only when high |
| gate | input | 1 | Note gate; rising edge opens, falling edge releases |
| atk_dcy | input | 8 | Rising rate in [7:4], falling-to-hold rate in [3:0] |
| sus_rel | input | 8 | Hold level nibble in [7:4], release rate in [3:0] |
| env_level | output | 8 | Current envelope level |
| env_phase | output | 2 | Current phase code |

## Verification
Every result is registered, so a gate edge or a rate match shows up at the outputs one enabled clock later. The rate register runs freely from reset, so the time to the first step is not fixed. The bench therefore never checks when the first step lands. It measures the gap between two consecutive level changes, sampling every cycle on the falling clock edge, because every step restarts the rate register. That gap must equal the rate period times the divider ratio for the level the step started from. For the rate-change case, the gap is counted from the last step before the change.

// File: rtl/env_pkg.sv
package env_pkg;

    localparam int LFSR_W   = 15;
    localparam int ENV_W    = 8;
    localparam int RATE_W   = 4;
    localparam int EXP_W    = 5;
    localparam int MAT_BITS = LFSR_W * LFSR_W;

    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 15'h6000;

    localparam logic [ENV_W-1:0] ENV_MAX = '1;

    // lower bounds of the falling-curve segments
    localparam logic [ENV_W-1:0] SEG_2  = 8'h37;
    localparam logic [ENV_W-1:0] SEG_4  = 8'h1B;
    localparam logic [ENV_W-1:0] SEG_8  = 8'h0F;
    localparam logic [ENV_W-1:0] SEG_16 = 8'h07;
    localparam logic [ENV_W-1:0] SEG_1  = 8'h5D;

    typedef enum logic [1:0] {
        PH_RELEASE = 2'd0,
        PH_ATTACK  = 2'd1,
        PH_DECAY   = 2'd2,
        PH_SUSTAIN = 2'd3
    } env_phase_e;

    typedef struct packed {
        env_phase_e       phase;
        logic [ENV_W-1:0] level;
        logic             gate;
    } env_state_t;

    function automatic int rate_period(input int r);
        case (r)
            0:  return 8;
            1:  return 31;
            2:  return 62;
            3:  return 94;
            4:  return 148;
            5:  return 219;
            6:  return 266;
            7:  return 312;
            8:  return 391;
            9:  return 976;
            10: return 1953;
            11: return 3125;
            12: return 3906;
            13: return 11719;
            14: return 19531;
            default: return 31250;
        endcase
    endfunction

    // GF(2) matrix product, rows packed LFSR_W bits each
    function automatic logic [MAT_BITS-1:0] mat_mul(input logic [MAT_BITS-1:0] a,
                                                    input logic [MAT_BITS-1:0] b);
        logic [MAT_BITS-1:0] c;
        logic [LFSR_W-1:0]   row;
        c = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            row = '0;
            for (int k = 0; k < LFSR_W; k++) begin
                if (a[i*LFSR_W + k]) row = row ^ b[k*LFSR_W +: LFSR_W];
            end
            c[i*LFSR_W +: LFSR_W] = row;
        end
        return c;
    endfunction

    // register contents after n shifts from the seed (square-and-multiply)
    function automatic logic [LFSR_W-1:0] lfsr_jump(input int n);
        logic [MAT_BITS-1:0] res;
        logic [MAT_BITS-1:0] base;
        logic [LFSR_W-1:0]   out;
        logic [15:0]         nn;
        nn = n[15:0];
        for (int j = 0; j < LFSR_W; j++) begin
            res[j*LFSR_W +: LFSR_W]  = LFSR_W'(1) << j;
            base[j*LFSR_W +: LFSR_W] = (j == 0) ? LFSR_TAPS : (LFSR_W'(1) << (j - 1));
        end
        for (int b = 0; b < 16; b++) begin
            if (nn[b]) res = mat_mul(base, res);
            base = mat_mul(base, base);
        end
        for (int j = 0; j < LFSR_W; j++) begin
            out[j] = ^(res[j*LFSR_W +: LFSR_W] & LFSR_SEED);
        end
        return out;
    endfunction

    function automatic logic [EXP_W-1:0] exp_divisor(input logic [ENV_W-1:0] lvl);
        if (lvl > SEG_1)        return 5'd1;
        else if (lvl >= SEG_2)  return 5'd2;
        else if (lvl >= SEG_4)  return 5'd4;
        else if (lvl >= SEG_8)  return 5'd8;
        else if (lvl >= SEG_16) return 5'd16;
        else                    return 5'd30;
    endfunction

endpackage

// File: rtl/env_rate_lfsr.sv
module env_rate_lfsr
    import env_pkg::*;
#(
    parameter int NUM_RATES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [LFSR_W-1:0] cmp_tab [NUM_RATES];
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
        localparam logic [LFSR_W-1:0] CMP_VAL = lfsr_jump(rate_period(g) - 1);
        assign cmp_tab[g] = CMP_VAL;
    end

    always_comb begin
        lfsr_d = lfsr_q;
        tick   = 1'b0;
        if (clk_en) begin
            if (lfsr_q == cmp_tab[rate]) begin
                tick   = 1'b1;
                lfsr_d = LFSR_SEED;
            end else begin
                lfsr_d = {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    // R3: the shift register never falls into the all-zero lock state
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R8: a match always restarts the register from the seed
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (lfsr_q == LFSR_SEED));

endmodule

// File: rtl/env_exp_div.sv
module env_exp_div
    import env_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             rate_tick,
    input  logic             active,
    input  logic             clear,
    input  logic [ENV_W-1:0] level,
    output logic             step
);

    logic [EXP_W-1:0] cnt_d, cnt_q;
    logic [EXP_W-1:0] div_now;
    logic [EXP_W:0]   cnt_inc;

    always_comb begin
        div_now = exp_divisor(level);
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        cnt_d   = cnt_q;
        step    = 1'b0;
        if (clk_en) begin
            if (clear) begin
                cnt_d = '0;
            end else if (rate_tick && active) begin
                if (cnt_inc >= {1'b0, div_now}) begin
                    step  = 1'b1;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_inc[EXP_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: pending matches stay below the ratio for the present level
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < exp_divisor(level));

endmodule

// File: rtl/env_adsr_gen.sv
module env_adsr_gen
    import env_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       gate,
    input  logic [7:0] atk_dcy,
    input  logic [7:0] sus_rel,
    output logic [7:0] env_level,
    output logic [1:0] env_phase
);

    env_state_t        state_d, state_q;
    logic [RATE_W-1:0] rate_sel;
    logic [ENV_W-1:0]  hold_lvl;
    logic              rate_tick, exp_step;
    logic              gate_rise, gate_fall;
    logic              fall_active;

    assign hold_lvl  = {sus_rel[7:4], sus_rel[7:4]};
    assign gate_rise = gate & ~state_q.gate;
    assign gate_fall = ~gate & state_q.gate;

    always_comb begin
        case (state_q.phase)
            PH_ATTACK:  rate_sel = atk_dcy[7:4];
            PH_RELEASE: rate_sel = sus_rel[3:0];
            default:    rate_sel = atk_dcy[3:0];
        endcase
        fall_active = ((state_q.phase == PH_DECAY) && (state_q.level > hold_lvl)) ||
                      ((state_q.phase == PH_RELEASE) && (state_q.level != '0));
    end

    env_rate_lfsr #(.NUM_RATES(16)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .rate   (rate_sel),
        .tick   (rate_tick)
    );

    env_exp_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .rate_tick (rate_tick),
        .active    (fall_active),
        .clear     (gate_rise | gate_fall),
        .level     (state_q.level),
        .step      (exp_step)
    );

    always_comb begin
        state_d = state_q;
        if (clk_en) begin
            state_d.gate = gate;
            if (gate_rise) begin
                state_d.phase = PH_ATTACK;
            end else if (gate_fall) begin
                state_d.phase = PH_RELEASE;
            end else begin
                case (state_q.phase)
                    PH_ATTACK: begin
                        if (state_q.level == ENV_MAX) begin
                            state_d.phase = PH_DECAY;
                        end else if (rate_tick) begin
                            state_d.level = state_q.level + 1'b1;
                            if (state_d.level == ENV_MAX) state_d.phase = PH_DECAY;
                        end
                    end
                    PH_DECAY: begin
                        if (state_q.level <= hold_lvl) begin
                            state_d.phase = PH_SUSTAIN;
                        end else if (exp_step) begin
                            state_d.level = state_q.level - 1'b1;
                            if (state_d.level == hold_lvl) state_d.phase = PH_SUSTAIN;
                        end
                    end
                    PH_RELEASE: begin
                        if (exp_step) state_d.level = state_q.level - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{phase: PH_RELEASE, level: '0, gate: 1'b0};
        else        state_q <= state_d;
    end

    assign env_level = state_q.level;
    assign env_phase = state_q.phase;

    // R2: the rising phase moves by at most one count per tick
    p_attack_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && state_q.phase == PH_ATTACK && gate && state_q.gate)
        |=> (state_q.level == $past(state_q.level)) ||
            ({1'b0, state_q.level} == {1'b0, $past(state_q.level)} + 9'd1));

    // R4: falling toward the hold level never undershoots it
    p_decay_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && state_q.phase == PH_DECAY && gate && state_q.gate &&
         state_q.level > hold_lvl)
        |=> state_q.level >= $past(hold_lvl));

    // R5: release only ever lowers the level
    p_release_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && state_q.phase == PH_RELEASE && !gate && !state_q.gate)
        |=> state_q.level <= $past(state_q.level));

    // R7: zero is sticky outside the rising phase
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && state_q.phase != PH_ATTACK && state_q.level == '0 &&
         !(gate && !state_q.gate))
        |=> state_q.level == '0);

    // R9: a disabled tick leaves the state untouched
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(state_q));

endmodule

// File: tb/env_adsr_gen_tb_top.sv
module env_adsr_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       gate = 1'b0;
    logic [7:0] atk_dcy = 8'h00;
    logic [7:0] sus_rel = 8'h00;
    logic [7:0] env_level;
    logic [1:0] env_phase;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    env_adsr_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .gate      (gate),
        .atk_dcy   (atk_dcy),
        .sus_rel   (sus_rel),
        .env_level (env_level),
        .env_phase (env_phase)
    );

    typedef struct packed {
        logic [3:0] rate;
        int         period;
    } rate_vec_t;

    localparam rate_vec_t RATE_VEC [6] = '{
        '{4'd0, 8}, '{4'd1, 31}, '{4'd2, 62},
        '{4'd3, 94}, '{4'd4, 148}, '{4'd8, 391}
    };

    typedef struct packed {
        logic [7:0] level;
        int         gap;
    } seg_vec_t;

    // release at rate 0 (8 ticks per match)
    localparam seg_vec_t SEG_VEC [7] = '{
        '{8'h5E, 8}, '{8'h5D, 16}, '{8'h20, 32}, '{8'h0F, 64},
        '{8'h0E, 128}, '{8'h07, 128}, '{8'h06, 240}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        gate   = 1'b0;
        clk_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_change(input int limit, output int cycles);
        logic [7:0] start;
        start  = env_level;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (env_level == start && cycles < limit);
    endtask

    task automatic wait_level(input logic [7:0] target, input int limit, output bit ok);
        int n;
        n = 0;
        while (env_level != target && n < limit) begin
            @(negedge clk);
            n++;
        end
        ok = (env_level == target);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int  gap;
        int  total;
        bit  ok;
        logic [7:0] lv;
        logic [1:0] ph;

        // table walk: rising-phase step period per rate (R3, R2, R1)
        for (int i = 0; i < 6; i++) begin
            atk_dcy = {RATE_VEC[i].rate, 4'h0};
            sus_rel = {4'hF, RATE_VEC[i].rate};
            do_reset();
            @(negedge clk);
            if (i == 0) begin
                check(env_level == 8'd0, "R1 level", env_level, 0);
                check(env_phase == 2'd0, "R1 phase", env_phase, 0);
            end
            repeat (2) @(negedge clk);
            gate = 1'b1;
            wait_change(RATE_VEC[i].period + 20, gap);
            check(env_phase == 2'd1, "R2 phase after rise", env_phase, 1);
            check(env_level == 8'd1, "R2 first step", env_level, 1);
            wait_change(2 * RATE_VEC[i].period, gap);
            check(gap == RATE_VEC[i].period, "R3 step period", gap, RATE_VEC[i].period);
        end

        // R2 / R4: full rise, fall to hold level 0xAA
        atk_dcy = 8'h00;
        sus_rel = 8'hA0;
        do_reset();
        gate = 1'b1;
        wait_level(8'hFF, 3000, ok);
        check(ok, "R2 reach full scale", env_level, 255);
        check(env_phase == 2'd2, "R2 phase at full scale", env_phase, 2);
        wait_level(8'hAA, 2000, ok);
        check(ok, "R4 reach hold level", env_level, 170);
        check(env_phase == 2'd3, "R4 holding phase", env_phase, 3);
        repeat (500) @(negedge clk);
        check(env_level == 8'hAA, "R4 level held", env_level, 170);

        // R5 / R9: release, then freeze with enable low
        gate = 1'b0;
        repeat (30) @(negedge clk);
        check(env_phase == 2'd0, "R5 release phase", env_phase, 0);
        check(env_level < 8'hAA, "R5 level falling", env_level, 169);
        lv = env_level;
        ph = env_phase;
        clk_en = 1'b0;
        gate   = 1'b1;
        repeat (300) @(negedge clk);
        check(env_level == lv, "R9 level frozen", env_level, lv);
        check(env_phase == ph, "R9 phase frozen", env_phase, ph);
        gate   = 1'b0;
        @(negedge clk);
        clk_en = 1'b1;

        // R6: gap per curve segment
        for (int i = 0; i < 7; i++) begin
            wait_level(SEG_VEC[i].level, 20000, ok);
            check(ok, "R6 segment reached", env_level, SEG_VEC[i].level);
            wait_change(1000, gap);
            check(gap == SEG_VEC[i].gap, "R6 segment gap", gap, SEG_VEC[i].gap);
        end

        // R7: sticky zero
        wait_level(8'h00, 3000, ok);
        check(ok, "R7 reach zero", env_level, 0);
        repeat (1000) @(negedge clk);
        check(env_level == 8'h00, "R7 zero held", env_level, 0);
        check(env_phase == 2'd0, "R7 phase stays release", env_phase, 0);

        // R8: rate lowered below current register position
        atk_dcy = {4'd9, 4'd0};
        sus_rel = {4'h0, 4'd9};
        do_reset();
        gate = 1'b1;
        wait_change(1100, gap);
        repeat (99) @(negedge clk);
        atk_dcy = 8'h00;
        wait_change(40000, gap);
        total = 99 + gap;
        check(total == 32775, "R8 wrap delay", total, 32775);
        wait_change(100, gap);
        check(gap == 8, "R8 normal pace resumes", gap, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule